// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Core

This block collects level-sensitive interrupt lines from a small multi-processor system. It decides, for each processor, which request that processor should serve next, and drives one interrupt line per processor. Software reaches it through a simple register bus. A select bit chooses between the shared (global) register window and the private window of the processor named on the bus. Enable and mask state is never written as a bitmap. Software writes a source number to a dedicated set or clear register, so there is no read-modify-write race between processors.

Sources come in two classes. Sources 1 to 28 are the per-processor class. Each processor masks them separately, and the routing word does not apply to them. Sources 29 and above form the shared class. They are steered by a routing word per source that holds one bit per processor. Source number 0 is not a line. It is the summary of the doorbell (inter-processor) requests addressed to the processor. The acknowledge register of a processor returns the lowest-numbered eligible request, or the code 1023 when nothing is pending. Reading it changes no state.

Top module: `mpic_core`

## Requirements
- R1: After reset every source is disabled, every per-processor-class source is masked for every processor, every routing word equals 1 (processor 0 only), all interrupt outputs are low and every acknowledge read returns 1023.
- R2: A read of global offset 0x000 returns the number of implemented sources in bits [11:2], and zero in all other bits.
- R3: Writing n to global offset 0x030 enables source n, and writing n to global offset 0x034 disables it. A written value of 0, or a value of NUM_SRC or more, changes no enable.
- R4: Writing n to per-processor offset 0x048 masks source n for the processor selected on the bus only, and offset 0x04C unmasks it. A value outside 1..28 changes no mask.
- R5: A per-processor-class source (1..28) is eligible for processor c exactly when its level is high, it is enabled, and it is unmasked for c. Its routing word has no effect.
- R6: A shared-class source (29..NUM_SRC-1) is eligible for processor c exactly when its level is high, it is enabled, and bit c of its routing word is set. Per-processor masks have no effect on it.
- R7: The routing word of source n sits at global offset 0x100 + 4n. Bits [NUM_CPUS-1:0] hold the routing bits. Other written bits are dropped and read as zero, and the word for source 0 always reads zero.
- R8: A read of per-processor offset 0x044 returns, in bits [9:0], the lowest-numbered eligible source for that processor, or 1023 if none. Bits [31:10] read as zero.
- R9: While doorbell[c] is high, the acknowledge read of processor c returns 0, ahead of every source.
- R10: cpu_irq[c] is high exactly when an acknowledge read by processor c would return a value other than 1023. It follows the inputs with no clock delay.
- R11: Reading the acknowledge register has no side effect: repeated reads under unchanged inputs return the same value.
- R12: Requests are level-sensitive: when a source's level falls, it stops being pending with no latched state.
- R13: Read data is presented in bus_rdata with bus_rvalid high in the cycle after a read request, and unmapped offsets in either window read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_global | input | 1 | 1 = global window, 0 = per-processor window |
| bus_cpu | input | CPU_W | Processor issuing the access (selects the per-processor window) |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High in the cycle after a read request |
| src_level | input | NUM_SRC-1 | Level of sources 1..NUM_SRC-1 (bit n = source n) |
| doorbell | input | NUM_CPUS | Doorbell summary per processor |
| cpu_irq | output | NUM_CPUS | Interrupt request to each processor |

## Verification
The bench targets the class boundary at sources 28 and 29. A design with an off-by-one there would gate source 28 by routing, or gate source 29 by the mask, and would return the wrong ID or 1023. It writes out-of-range source numbers whose low bits alias a live source (104 aliases 40). A decoder that truncates before range-checking would silently disable source 40. It also checks that a mask write from one processor leaves the other processor's view unchanged, and that routing bits beyond the processor count are dropped. It shows the doorbell code 0 beating every line, and the lowest ID winning when several are pending. Repeated acknowledge reads, falling levels and a mid-run reset catch any design that latches requests or changes state on a read.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;

  localparam logic [ID_W-1:0] ID_NONE = 10'h3FF;

  // global window
  localparam logic [ADDR_W-1:0] G_CTRL       = 12'h000;
  localparam logic [ADDR_W-1:0] G_EN_SET     = 12'h030;
  localparam logic [ADDR_W-1:0] G_EN_CLR     = 12'h034;
  localparam logic [ADDR_W-1:0] G_ROUTE_BASE = 12'h100;

  // per-processor window
  localparam logic [ADDR_W-1:0] C_ACK        = 12'h044;
  localparam logic [ADDR_W-1:0] C_MASK_SET   = 12'h048;
  localparam logic [ADDR_W-1:0] C_MASK_CLR   = 12'h04C;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EN_SET,
    OP_EN_CLR,
    OP_ROUTE_WR,
    OP_MASK_SET,
    OP_MASK_CLR
  } wr_op_e;

endpackage

// File: rtl/mpic_src_state.sv
module mpic_src_state
  import mpic_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPUS = 2,
  parameter int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  wr_op_e                             op,
  input  logic [SRC_W-1:0]                   wr_id,
  input  logic [NUM_CPUS-1:0]                route_wr,
  output logic [NUM_SRC-1:1]                 en_o,
  output logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route_o
);

  assign route_o[0] = '0;   // ID 0 is the doorbell summary, not a line

  for (genvar n = 1; n < NUM_SRC; n++) begin : g_src
    logic                en_q, en_d, en_ce;
    logic [NUM_CPUS-1:0] route_q, route_d;
    logic                route_ce;
    logic                hit;

    always_comb begin
      hit      = (wr_id == SRC_W'(n));
      en_ce    = hit && ((op == OP_EN_SET) || (op == OP_EN_CLR));
      en_d     = (op == OP_EN_SET);
      route_ce = hit && (op == OP_ROUTE_WR);
      route_d  = route_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q    <= 1'b0;
        route_q <= NUM_CPUS'(1);
      end else begin
        if (en_ce)    en_q    <= en_d;
        if (route_ce) route_q <= route_d;
      end
    end

    assign en_o[n]    = en_q;
    assign route_o[n] = route_q;
  end

  // R3: a decoded set lands in the addressed enable bit
  a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EN_SET) |=> en_o[$past(wr_id)]);

  // R3: a decoded clear drops the addressed enable bit
  a_r3_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EN_CLR) |=> !en_o[$past(wr_id)]);

  // R7: a routing write is held as written
  a_r7_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROUTE_WR && wr_id != '0) |=> (route_o[$past(wr_id)] == $past(route_wr)));

endmodule

// File: rtl/mpic_cpu_mask.sv
module mpic_cpu_mask
  import mpic_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int PERCPU_LAST = 28,
  parameter int NUM_CPUS    = 2,
  parameter int CPU_ID      = 0,
  parameter int SRC_W       = $clog2(NUM_SRC),
  parameter int CPU_W       = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  wr_op_e                  op,
  input  logic [SRC_W-1:0]        wr_id,
  input  logic [CPU_W-1:0]        wr_cpu,
  output logic [PERCPU_LAST:1]    mask_o
);

  logic mine;
  assign mine = (wr_cpu == CPU_W'(CPU_ID));

  for (genvar n = 1; n <= PERCPU_LAST; n++) begin : g_bit
    logic mask_q, mask_d, mask_ce;

    always_comb begin
      mask_ce = mine && (wr_id == SRC_W'(n)) &&
                ((op == OP_MASK_SET) || (op == OP_MASK_CLR));
      mask_d  = (op == OP_MASK_SET);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= 1'b1;
      else if (mask_ce) mask_q <= mask_d;
    end

    assign mask_o[n] = mask_q;
  end

  // R4: mask traffic aimed at another processor leaves this one untouched
  a_r4_other_cpu_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_MASK_SET || op == OP_MASK_CLR) && !mine) |=> $stable(mask_o));

  // R4: an unmask for this processor clears the addressed bit
  a_r4_unmask_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MASK_CLR && mine && wr_id != '0 && wr_id <= SRC_W'(PERCPU_LAST))
      |=> !mask_o[$past(wr_id)]);

endmodule

// File: rtl/mpic_pick.sv
module mpic_pick
  import mpic_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int PERCPU_LAST = 28
) (
  input  logic [NUM_SRC-1:1]   level,
  input  logic [NUM_SRC-1:1]   en,
  input  logic [NUM_SRC-1:1]   route_col,
  input  logic [PERCPU_LAST:1] mask,
  input  logic                 doorbell,
  output logic [ID_W-1:0]      ack_id,
  output logic                 irq
);

  logic [NUM_SRC-1:0] elig;

  assign elig[0] = doorbell;

  for (genvar n = 1; n < NUM_SRC; n++) begin : g_elig
    if (n <= PERCPU_LAST) begin : g_local
      assign elig[n] = level[n] & en[n] & ~mask[n];
    end else begin : g_shared
      assign elig[n] = level[n] & en[n] & route_col[n];
    end
  end

  // lowest index wins
  always_comb begin
    ack_id = ID_NONE;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (elig[n]) ack_id = ID_W'(n);
    end
  end

  assign irq = |elig;

endmodule

// File: rtl/mpic_core.sv
module mpic_core
  import mpic_pkg::*;
#(
  parameter int NUM_CPUS    = 2,
  parameter int NUM_SRC     = 64,
  parameter int PERCPU_LAST = 28,
  parameter int CPU_W       = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic                 bus_global,
  input  logic [CPU_W-1:0]     bus_cpu,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_SRC-1:1]   src_level,
  input  logic [NUM_CPUS-1:0]  doorbell,
  output logic [NUM_CPUS-1:0]  cpu_irq
);

  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int MASK_W = $clog2(PERCPU_LAST + 1);

  // ---------------- reset: async assert, sync release ----------------
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // ---------------- decode ----------------
  logic              wr_fire, rd_fire;
  logic              id_ok, pc_ok;
  logic [ADDR_W-1:0] rofs;
  logic              route_hit;
  logic [SRC_W-1:0]  route_idx;
  wr_op_e            op;
  logic [SRC_W-1:0]  wid;

  always_comb begin
    wr_fire   = bus_req & bus_we;
    rd_fire   = bus_req & ~bus_we;
    id_ok     = (bus_wdata != '0) && (bus_wdata < DATA_W'(NUM_SRC));
    pc_ok     = id_ok && (bus_wdata <= DATA_W'(PERCPU_LAST));
    rofs      = bus_addr - G_ROUTE_BASE;
    route_hit = (bus_addr >= G_ROUTE_BASE) && (rofs < ADDR_W'(4 * NUM_SRC)) &&
                (rofs[1:0] == 2'b00);
    route_idx = rofs[SRC_W+1:2];
  end

  always_comb begin
    op  = OP_NONE;
    wid = bus_wdata[SRC_W-1:0];
    if (wr_fire) begin
      if (bus_global) begin
        if (bus_addr == G_EN_SET && id_ok)      op = OP_EN_SET;
        else if (bus_addr == G_EN_CLR && id_ok) op = OP_EN_CLR;
        else if (route_hit) begin
          op  = OP_ROUTE_WR;
          wid = route_idx;
        end
      end else begin
        if (bus_addr == C_MASK_SET && pc_ok)      op = OP_MASK_SET;
        else if (bus_addr == C_MASK_CLR && pc_ok) op = OP_MASK_CLR;
      end
    end
  end

  // ---------------- state ----------------
  logic [NUM_SRC-1:1]                en_vec;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0]  route_vec;

  mpic_src_state #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CPUS (NUM_CPUS),
    .SRC_W    (SRC_W)
  ) u_src_state (
    .clk      (clk),
    .rst_n    (rst_q),
    .op       (op),
    .wr_id    (wid),
    .route_wr (bus_wdata[NUM_CPUS-1:0]),
    .en_o     (en_vec),
    .route_o  (route_vec)
  );

  logic [NUM_CPUS-1:0][NUM_SRC-1:1]     route_col;
  logic [NUM_CPUS-1:0][PERCPU_LAST:1]   mask_all;
  logic [NUM_CPUS-1:0][ID_W-1:0]        ack_id;

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int n = 1; n < NUM_SRC; n++) begin
        route_col[c][n] = route_vec[n][c];
      end
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    mpic_cpu_mask #(
      .NUM_SRC     (NUM_SRC),
      .PERCPU_LAST (PERCPU_LAST),
      .NUM_CPUS    (NUM_CPUS),
      .CPU_ID      (c),
      .SRC_W       (SRC_W),
      .CPU_W       (CPU_W)
    ) u_mask (
      .clk    (clk),
      .rst_n  (rst_q),
      .op     (op),
      .wr_id  (wid),
      .wr_cpu (bus_cpu),
      .mask_o (mask_all[c])
    );

    mpic_pick #(
      .NUM_SRC     (NUM_SRC),
      .PERCPU_LAST (PERCPU_LAST)
    ) u_pick (
      .level     (src_level),
      .en        (en_vec),
      .route_col (route_col[c]),
      .mask      (mask_all[c]),
      .doorbell  (doorbell[c]),
      .ack_id    (ack_id[c]),
      .irq       (cpu_irq[c])
    );

    // R10: interrupt line agrees with the acknowledge value
    a_r10_irq_vs_ack: assert property (@(posedge clk) disable iff (!rst_q)
      cpu_irq[c] == (ack_id[c] != ID_NONE));

    // R9: doorbell code takes precedence
    a_r9_doorbell_first: assert property (@(posedge clk) disable iff (!rst_q)
      doorbell[c] |-> (ack_id[c] == '0));

    // R5: a masked per-processor source is never acknowledged
    a_r5_masked_not_acked: assert property (@(posedge clk) disable iff (!rst_q)
      (ack_id[c] != '0 && ack_id[c] <= ID_W'(PERCPU_LAST))
        |-> !mask_all[c][ack_id[c][MASK_W-1:0]]);
  end

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q;

  always_comb begin
    rdata_d = '0;
    if (bus_global) begin
      if (bus_addr == G_CTRL)  rdata_d = DATA_W'(NUM_SRC) << 2;
      else if (route_hit)      rdata_d = DATA_W'(route_vec[route_idx]);
    end else if (bus_addr == C_ACK) begin
      rdata_d = DATA_W'(ack_id[bus_cpu]);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R13: every read request yields valid data next cycle
  a_r13_read_valid: assert property (@(posedge clk) disable iff (!rst_q)
    rd_fire |=> bus_rvalid);

  // R13: no valid strobe without a read
  a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_fire |=> !bus_rvalid);

  // R2: control register reports the source count
  a_r2_ctrl_count: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_fire && bus_global && bus_addr == G_CTRL) |=> (bus_rdata[11:2] == 10'(NUM_SRC)));

endmodule

// File: tb/mpic_core_bench.sv
module mpic_core_bench;
  import mpic_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_global = 1'b0;
  logic [0:0]  bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:1] src_level = '0;
  logic [1:0]  doorbell = '0;
  logic [1:0]  cpu_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mpic_core u_mpic_core (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_global(bus_global), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .src_level(src_level), .doorbell(doorbell), .cpu_irq(cpu_irq)
  );

  typedef struct packed {
    logic        rd;
    logic        glob;
    logic        cpu;
    logic [11:0] addr;
    logic [31:0] data;
    logic [63:0] lvl;
    logic [1:0]  db;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t V(input logic rd, input logic glob, input logic cpu,
                             input logic [11:0] a, input logic [31:0] d,
                             input logic [63:0] l, input logic [1:0] db,
                             input logic [7:0] r);
    V = '{rd: rd, glob: glob, cpu: cpu, addr: a, data: d, lvl: l, db: db, req: r};
  endfunction

  localparam logic [63:0] L3  = 64'h8;
  localparam logic [63:0] L5  = 64'h20;
  localparam logic [63:0] L28 = 64'h1000_0000;
  localparam logic [63:0] L29 = 64'h2000_0000;
  localparam logic [63:0] L40 = 64'h0000_0100_0000_0000;
  localparam logic [63:0] L63 = 64'h8000_0000_0000_0000;

  localparam int NV = 52;
  localparam vec_t VT [NV] = '{
    V(1,1,0,12'h000,32'h100,0,0,2),          // R2 source count
    V(1,0,0,12'h044,32'h3FF,0,0,1),          // R1
    V(1,0,1,12'h044,32'h3FF,0,0,1),          // R1
    V(1,1,0,12'h114,32'h1,0,0,1),            // R1 default route
    V(1,0,0,12'h044,32'h3FF,L5,0,3),         // R3 disabled at reset
    V(0,1,0,12'h030,32'd5,L5,0,3),           // R3 enable 5
    V(1,0,0,12'h044,32'h3FF,L5,0,1),         // R1 masked at reset
    V(0,0,0,12'h04C,32'd5,L5,0,4),           // R4 unmask 5 cpu0
    V(1,0,0,12'h044,32'd5,L5,0,5),           // R5
    V(1,0,1,12'h044,32'h3FF,L5,0,4),         // R4 cpu1 still masked
    V(0,1,0,12'h114,32'h2,L5,0,7),           // R7 route 5 -> cpu1
    V(1,1,0,12'h114,32'h2,L5,0,7),           // R7
    V(1,0,0,12'h044,32'd5,L5,0,5),           // R5 routing ignored
    V(1,0,0,12'h044,32'h3FF,0,0,12),         // R12 level dropped
    V(0,1,0,12'h030,32'd40,0,0,3),           // R3 enable 40
    V(1,0,0,12'h044,32'd40,L40,0,6),         // R6
    V(1,0,1,12'h044,32'h3FF,L40,0,6),        // R6
    V(0,1,0,12'h1A0,32'hFFFF_FFFE,L40,0,7),  // R7 extra bits dropped
    V(1,1,0,12'h1A0,32'h2,L40,0,7),          // R7
    V(1,0,1,12'h044,32'd40,L40,0,6),         // R6
    V(1,0,0,12'h044,32'h3FF,L40,0,6),        // R6
    V(0,0,1,12'h048,32'd40,L40,0,4),         // R4 mask on shared id ignored
    V(1,0,1,12'h044,32'd40,L40,0,4),         // R4
    V(0,1,0,12'h034,32'd104,L40,0,3),        // R3 out-of-range clear
    V(1,0,1,12'h044,32'd40,L40,0,3),         // R3
    V(0,1,0,12'h030,32'd3,0,0,3),            // R3
    V(0,0,0,12'h04C,32'd3,0,0,4),            // R4
    V(1,0,0,12'h044,32'd3,L3|L5|L40,0,8),    // R8 lowest wins
    V(0,1,0,12'h034,32'd3,L3|L5|L40,0,3),    // R3 disable 3
    V(1,0,0,12'h044,32'd5,L3|L5|L40,0,3),    // R3
    V(1,0,0,12'h044,32'd0,L5,2'b01,9),       // R9
    V(1,0,1,12'h044,32'h3FF,0,2'b01,9),      // R9 other cpu
    V(1,0,1,12'h044,32'd0,L40,2'b10,9),      // R9
    V(1,1,0,12'h010,32'h0,0,0,13),           // R13 unmapped global
    V(1,1,0,12'h100,32'h0,0,0,7),            // R7 source 0 word
    V(1,0,0,12'h040,32'h0,L5,0,13),          // R13 unmapped per-cpu
    V(0,0,0,12'h048,32'd5,L5,0,4),           // R4 mask 5 cpu0
    V(1,0,0,12'h044,32'h3FF,L5,0,4),         // R4
    V(0,1,0,12'h034,32'd40,L40,0,3),         // R3 disable 40
    V(1,0,1,12'h044,32'h3FF,L40,0,3),        // R3
    V(0,1,0,12'h030,32'd28,0,0,3),           // R3
    V(1,0,0,12'h044,32'h3FF,L28,0,5),        // R5 28 is per-cpu class
    V(0,0,0,12'h04C,32'd28,L28,0,4),         // R4
    V(1,0,0,12'h044,32'd28,L28,0,5),         // R5
    V(0,1,0,12'h030,32'd29,0,0,3),           // R3
    V(1,0,0,12'h044,32'd29,L29,0,6),         // R6 29 is shared class
    V(1,0,1,12'h044,32'h3FF,L29,0,6),        // R6
    V(0,1,0,12'h030,32'd63,0,0,3),           // R3
    V(0,1,0,12'h1FC,32'h3,0,0,7),            // R7 route 63 to both
    V(1,0,0,12'h044,32'd63,L63,0,6),         // R6
    V(1,0,1,12'h044,32'd63,L63,0,6),         // R6
    V(1,0,0,12'h044,32'd28,L28|L29|L63,0,8)  // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input vec_t v, output logic [31:0] got, output logic gv);
    @(negedge clk);
    src_level  = v.lvl[63:1];
    doorbell   = v.db;
    bus_req    = 1'b1;
    bus_we     = ~v.rd;
    bus_global = v.glob;
    bus_cpu    = v.cpu;
    bus_addr   = v.addr;
    bus_wdata  = v.data;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
    got = bus_rdata;
    gv  = bus_rvalid;
  endtask

  task automatic rd_ack(input logic cpu, output logic [31:0] got);
    logic gv;
    access(V(1,0,cpu,12'h044,0,{src_level,1'b0},doorbell,0), got, gv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] got, got2;
    logic        gv;
    // R1 reset state
    src_level = L63[63:1];
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {30'd0, cpu_irq}, 32'd0);
    check("R1 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 irq after reset", {30'd0, cpu_irq}, 32'd0);
    src_level = '0;

    for (int i = 0; i < NV; i++) begin
      access(VT[i], got, gv);
      if (VT[i].rd) begin
        check($sformatf("R%0d vec %0d", VT[i].req, i), got, VT[i].data);
        check($sformatf("R13 rvalid vec %0d", i), {31'd0, gv}, 32'd1);
        if (!VT[i].glob && VT[i].addr == 12'h044)
          check($sformatf("R10 irq vec %0d", i), {31'd0, cpu_irq[VT[i].cpu]},
                {31'd0, VT[i].data != 32'h3FF});
      end
    end

    // R10 / R11 / R12 directed
    @(negedge clk);
    src_level = L63[63:1];
    doorbell  = '0;
    #1 check("R10 irq both on shared 63", {30'd0, cpu_irq}, 32'd3);
    rd_ack(1'b0, got);
    rd_ack(1'b0, got2);
    check("R11 first ack read", got, 32'd63);
    check("R11 repeated ack read", got2, 32'd63);
    @(negedge clk);
    src_level = L29[63:1];
    #1 check("R6 irq only cpu0 for 29", {30'd0, cpu_irq}, 32'd1);
    src_level = '0;
    #1 check("R12 irq drop with level", {30'd0, cpu_irq}, 32'd0);

    // R1 reset mid-run
    @(negedge clk);
    src_level = L63[63:1];
    rst_n = 1'b0;
    #1 check("R1 irq cleared by reset", {30'd0, cpu_irq}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_ack(1'b0, got);
    check("R1 enables cleared", got, 32'h3FF);
    access(V(1,1,0,12'h1A0,0,L63,0,0), got, gv);
    check("R1 route restored", got, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule